// File: doc/BRIEF.md
# Panel Timing-Generator Power Sequencer

This block steps an LCD timing generator through its power-up and power-down recipes. Each recipe is a fixed list of steps. A step is a write of a 5-bit value to one of eight 3-bit register addresses, a wait of a whole number of milliseconds, or a single transfer handed to a common-voltage bias DAC. Register writes leave through a valid/ready port toward a serial sender, and the DAC transfer leaves through a second valid/ready port. The analog rails and the serial transport sit outside the block.

A power-up request from an uninitialised state runs the full bring-up. It sets the panel phase from the display mode and an optional stored phase, sets the DAC bias from an optional stored value, writes the resolution and raises the initialised flag. A power-up request while the panel is already initialised rewrites only the phase and the resolution. A power-down request waits about two frame times, walks the rails back down, drives the bias to zero and clears the flag.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `wr_valid`, `dac_valid` and `init_done` are all 0.
- R2: A power-up from the uninitialised state issues these (address, data) writes in this order: (6,0x1F) (3,0x03) (4,0x00) (4,0x04), wait 3 ms, (3,0x07) (6,0x09), DAC transfer, (3,0x17) (4,0x06), wait 2 ms, (6,0x01) (3,0x1F) (4,0x07) (6,0x00), phase write to address 1, (7,0x00), wait 1 ms, resolution write to address 0.
- R3: The power-up DAC transfer carries base 0x04 and code `comv_val` when `comv_valid` was set at the request, and code 125 otherwise. No register write is offered while a DAC transfer is pending.
- R4: The phase data is 0x13 in QVGA mode (`mode_vga`=0). In VGA mode it is {`phase_val`,1} when `phase_valid` was set, and 0x01 otherwise.
- R5: The resolution write (address 0) carries 1 for QVGA and 0 for VGA. It is the last write of a power-up, and `init_done` rises on the clock edge that follows its acceptance.
- R6: A power-up request while `init_done` is 1 issues only the phase write and then the resolution write.
- R7: A power-down issues, after its wait, (4,0x06) (6,0x08) (3,0x14), then a DAC transfer with base 0x14 and code 0, then (4,0x04) (3,0x04) (6,0x1E) (3,0x00) (4,0x00). `init_done` falls on the edge that accepts the last write.
- R8: An n-millisecond wait lasts exactly n×`CLK_PER_MS` cycles. The power-down wait is 34 ms. With the sender always ready, the write after a wait is accepted n×`CLK_PER_MS`+1 cycles after the step before it.
- R9: An offered register write or DAC transfer keeps its valid, address, data, base and code unchanged until it is accepted.
- R10: Requests that arrive while a sequence runs are ignored. When power-up and power-down are requested together while idle, power-down runs. Mode, phase and bias inputs are captured when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Power-up or re-initialise request |
| down_req | input | 1 | Power-down request |
| mode_vga | input | 1 | 1 = VGA, 0 = QVGA |
| phase_valid | input | 1 | A stored phase value is present |
| phase_val | input | 4 | Stored phase value |
| comv_valid | input | 1 | A stored bias value is present |
| comv_val | input | 8 | Stored bias code |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Sender accepts the write |
| wr_addr | output | 3 | Register address |
| wr_data | output | 5 | Register data |
| dac_valid | output | 1 | DAC transfer offered |
| dac_ready | input | 1 | DAC transfer completed |
| dac_base | output | 5 | Rail bits that accompany the transfer |
| dac_code | output | 8 | Bias code |
| init_done | output | 1 | Panel initialised |

## Verification
On every cycle the assertions check four things. Offered transfers stay stable until accepted. The two ports are never offered at once. The initialised flag changes only right after the final write of its sequence. Every phase and resolution write has a legal data shape. The exact order and values of each recipe, the bias and phase choices under every combination of mode and stored-value flags, the wait lengths in cycles and the ignoring of mid-sequence requests can only be shown by the bench's scenarios. Those scenarios compare the accepted write stream against lists built from the requirements, under both an always-ready sender and a stalling one.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int CLK_PER_MS = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req,
  input  logic       down_req,
  input  logic       mode_vga,
  input  logic       phase_valid,
  input  logic [3:0] phase_val,
  input  logic       comv_valid,
  input  logic [7:0] comv_val,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [2:0] wr_addr,
  output logic [4:0] wr_data,
  output logic       dac_valid,
  input  logic       dac_ready,
  output logic [4:0] dac_base,
  output logic [7:0] dac_code,
  output logic       init_done
);
  localparam int LONG_MS = 34;
  localparam int CW = $clog2(LONG_MS * CLK_PER_MS + 1);
  localparam logic [4:0] PC_UP = 5'd0, PC_RE = 5'd19, PC_DN = 5'd21, PC_DN_END = 5'd30;
  localparam logic [1:0] OP_WR = 2'd0, OP_WAIT = 2'd1, OP_DAC = 2'd2;
  localparam logic [7:0] COMV_DFLT = 8'd125;

  logic          busy, mode_q;
  logic [4:0]    pc, ph_q;
  logic [7:0]    cv_q;
  logic [CW-1:0] cnt, lim;
  logic [1:0]    op;
  logic [2:0]    a;
  logic [4:0]    d;
  logic [5:0]    nms;
  logic          last, step_done;

  always_comb begin
    op = OP_WR; a = 3'd0; d = 5'h00; nms = 6'd1; last = 1'b0;
    case (pc)
      5'd0:  begin a = 3'd6; d = 5'h1F; end
      5'd1:  begin a = 3'd3; d = 5'h03; end
      5'd2:  begin a = 3'd4; d = 5'h00; end
      5'd3:  begin a = 3'd4; d = 5'h04; end
      5'd4:  begin op = OP_WAIT; nms = 6'd3; end
      5'd5:  begin a = 3'd3; d = 5'h07; end
      5'd6:  begin a = 3'd6; d = 5'h09; end
      5'd7:  begin op = OP_DAC; d = 5'h04; end
      5'd8:  begin a = 3'd3; d = 5'h17; end
      5'd9:  begin a = 3'd4; d = 5'h06; end
      5'd10: begin op = OP_WAIT; nms = 6'd2; end
      5'd11: begin a = 3'd6; d = 5'h01; end
      5'd12: begin a = 3'd3; d = 5'h1F; end
      5'd13: begin a = 3'd4; d = 5'h07; end
      5'd14: begin a = 3'd6; d = 5'h00; end
      5'd15: begin a = 3'd1; d = ph_q; end
      5'd16: begin a = 3'd7; d = 5'h00; end
      5'd17: begin op = OP_WAIT; nms = 6'd1; end
      5'd18: begin a = 3'd0; d = {4'd0, ~mode_q}; last = 1'b1; end
      5'd19: begin a = 3'd1; d = ph_q; end
      5'd20: begin a = 3'd0; d = {4'd0, ~mode_q}; last = 1'b1; end
      5'd21: begin op = OP_WAIT; nms = 6'(LONG_MS); end
      5'd22: begin a = 3'd4; d = 5'h06; end
      5'd23: begin a = 3'd6; d = 5'h08; end
      5'd24: begin a = 3'd3; d = 5'h14; end
      5'd25: begin op = OP_DAC; d = 5'h14; end
      5'd26: begin a = 3'd4; d = 5'h04; end
      5'd27: begin a = 3'd3; d = 5'h04; end
      5'd28: begin a = 3'd6; d = 5'h1E; end
      5'd29: begin a = 3'd3; d = 5'h00; end
      5'd30: begin a = 3'd4; d = 5'h00; last = 1'b1; end
      default: begin op = OP_WAIT; last = 1'b1; end
    endcase
  end

  assign lim = CW'(nms) * CW'(CLK_PER_MS);
  assign step_done = (op == OP_WR   && wr_ready) ||
                     (op == OP_DAC  && dac_ready) ||
                     (op == OP_WAIT && cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pc <= PC_UP; cnt <= '0; init_done <= 1'b0;
      mode_q <= 1'b0; ph_q <= 5'd0; cv_q <= 8'd0;
    end else if (!busy) begin
      cnt <= '0;
      if (down_req) begin
        busy <= 1'b1; pc <= PC_DN;
      end else if (up_req) begin
        busy   <= 1'b1;
        pc     <= init_done ? PC_RE : PC_UP;
        mode_q <= mode_vga;
        ph_q   <= !mode_vga ? 5'h13 : (phase_valid ? {phase_val, 1'b1} : 5'h01);
        cv_q   <= comv_valid ? comv_val : COMV_DFLT;
      end
    end else if (step_done) begin
      cnt <= '0;
      if (last) begin
        busy      <= 1'b0;
        init_done <= (pc != PC_DN_END);
      end else begin
        pc <= pc + 5'd1;
      end
    end else if (op == OP_WAIT) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign wr_valid  = busy && op == OP_WR;
  assign wr_addr   = a;
  assign wr_data   = d;
  assign dac_valid = busy && op == OP_DAC;
  assign dac_base  = d;
  assign dac_code  = (pc == PC_DN + 5'd4) ? 8'd0 : cv_q;
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [2:0] wr_addr,
  input logic [4:0] wr_data,
  input logic       dac_valid,
  input logic       dac_ready,
  input logic [4:0] dac_base,
  input logic [7:0] dac_code,
  input logic       init_done
);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R9
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_base) && $stable(dac_code));
  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && dac_valid));
  // R5
  init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(wr_valid && wr_ready && wr_addr == 3'd0));
  // R7
  init_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> $past(wr_valid && wr_ready && wr_addr == 3'd4 && wr_data == 5'd0));
  // R5
  res_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'd0 |-> wr_data[4:1] == 4'd0);
  // R4
  phase_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == 3'd1 |-> wr_data[0]);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (.*);

// File: tb/panel_pwr_seq_tb.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb;
  localparam int K = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_req = 0, down_req = 0, mode_vga = 0, phase_valid = 0, comv_valid = 0;
  logic [3:0] phase_val = 0;
  logic [7:0] comv_val = 0;
  logic wr_valid, wr_ready = 1, dac_valid, dac_ready = 0, init_done;
  logic [2:0] wr_addr;
  logic [4:0] wr_data, dac_base;
  logic [7:0] dac_code;

  panel_pwr_seq #(.CLK_PER_MS(K)) u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, n_got = 0, n_dac = 0, n_exp = 0, dwait = 0, req_stamp = 0;
  int got_a[64], got_d[64], got_t[64], exp_a[64], exp_d[64];
  int dac_b = 0, dac_c = 0;
  bit stall = 0, finished = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
    dac_ready = dac_valid && dwait >= 3;
    #1;
    if (wr_valid && wr_ready && n_got < 64) begin
      got_a[n_got] = wr_addr; got_d[n_got] = wr_data; got_t[n_got] = cyc; n_got++;
    end
    if (dac_valid && dac_ready) begin
      dac_b = dac_base; dac_c = dac_code; n_dac++; dwait = 0;
    end else if (dac_valid) dwait++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    checks++; fails++;
    summary();
  end

  task automatic push(input int a, input int d);
    exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++;
  endtask

  task automatic build_up(input bit vga, input bit pv, input int ph);
    int phx;
    phx = !vga ? 19 : (pv ? ph * 2 + 1 : 1);
    n_exp = 0;
    push(6,31); push(3,3); push(4,0); push(4,4); push(3,7); push(6,9);
    push(3,23); push(4,6); push(6,1); push(3,31); push(4,7); push(6,0);
    push(1,phx); push(7,0); push(0, vga ? 0 : 1);
  endtask

  task automatic build_dn();
    n_exp = 0;
    push(4,6); push(6,8); push(3,20); push(4,4); push(3,4); push(6,30); push(3,0); push(4,0);
  endtask

  task automatic pulse(input bit u, input bit d);
    @(negedge clk); #2;
    req_stamp = cyc; up_req = u; down_req = d;
    @(negedge clk); #2;
    up_req = 0; down_req = 0;
  endtask

  task automatic run(input bit u, input bit d);
    n_got = 0; n_dac = 0;
    pulse(u, d);
    while (n_got < n_exp) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(n_got == n_exp, {req, " count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_a[i] == exp_a[i], {req, " addr"}, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
    end
  endtask

  task automatic gap(input int i, input int g, input string req);
    chk(got_t[i+1] - got_t[i] == g, req, got_t[i+1] - got_t[i], g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    chk(dac_valid == 0, "R1 dac_valid", dac_valid, 0);
    chk(init_done == 0, "R1 init_done", init_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int cfg = 0; cfg < 16; cfg++) begin
      bit vga, pv, cv;
      vga = cfg[0]; pv = cfg[1]; cv = cfg[2]; stall = cfg[3];
      mode_vga = vga; phase_valid = pv; comv_valid = cv;
      phase_val = 4'(cfg * 5 + 3); comv_val = 8'(cfg * 17 + 40);
      // R2 R3 R4 R5 R8: full power-up
      build_up(vga, pv, int'(phase_val));
      run(1, 0);
      compare("R2");
      chk(n_dac == 1, "R3 dac count", n_dac, 1);
      chk(dac_b == 4, "R3 dac base", dac_b, 4);
      chk(dac_c == (cv ? int'(comv_val) : 125), "R3 dac code", dac_c, cv ? int'(comv_val) : 125);
      chk(got_d[12] == exp_d[12], "R4 phase", got_d[12], exp_d[12]);
      chk(got_d[14] == (vga ? 0 : 1), "R5 resolution", got_d[14], vga ? 0 : 1);
      chk(init_done == 1, "R5 init_done", init_done, 1);
      if (!stall) begin
        gap(3, 3*K+1, "R8 3ms");
        gap(7, 2*K+1, "R8 2ms");
        gap(13, K+1, "R8 1ms");
        gap(0, 1, "R8 back-to-back");
      end
      // R6: repeat request, inputs changed
      mode_vga = ~vga; phase_valid = 1; phase_val = 4'(cfg + 1);
      n_exp = 0;
      push(1, vga ? 19 : (cfg + 1) * 2 + 1); push(0, vga ? 1 : 0);
      run(1, 0);
      compare("R6");
      chk(n_dac == 0, "R6 no dac", n_dac, 0);
      chk(init_done == 1, "R6 init_done", init_done, 1);
      // R7 R8: power-down
      build_dn();
      run(0, 1);
      compare("R7");
      chk(n_dac == 1, "R7 dac count", n_dac, 1);
      chk(dac_b == 20, "R7 dac base", dac_b, 20);
      chk(dac_c == 0, "R7 dac code", dac_c, 0);
      chk(init_done == 0, "R7 init_done", init_done, 0);
      if (!stall) chk(got_t[0] - req_stamp == 34*K+1, "R8 34ms", got_t[0] - req_stamp, 34*K+1);
    end

    // R10: simultaneous requests while idle -> power-down runs
    stall = 0;
    build_dn();
    run(1, 1);
    compare("R10 both");
    chk(init_done == 0, "R10 both init", init_done, 0);

    // R10: requests mid-sequence ignored; inputs captured at request
    mode_vga = 1; phase_valid = 1; phase_val = 4'd6; comv_valid = 1; comv_val = 8'd77;
    build_up(1, 1, 6);
    n_got = 0; n_dac = 0;
    pulse(1, 0);
    mode_vga = 0; comv_val = 8'd3;
    repeat (5) @(negedge clk);
    pulse(0, 1);
    repeat (20) @(negedge clk);
    pulse(1, 1);
    while (n_got < n_exp) @(negedge clk);
    repeat (40) @(negedge clk);
    compare("R10 ignore");
    chk(dac_c == 77, "R10 captured code", dac_c, 77);
    chk(init_done == 1, "R10 init_done", init_done, 1);
    summary();
  end
endmodule